// File: doc/BRIEF.md
# Guarded Byte-Store Write Controller

This block sits between a processor's register bus and a small byte-wide nonvolatile data store. Software sees four byte registers: an address register, a data register, a control/status register and a key register that holds no state. A read is one control write followed by one cycle of latency. A write is accepted only after two fixed key bytes arrive in order and write-enable is already on. It then runs for a fixed number of clocks and raises a sticky completion flag when it ends.

The store is a plain synchronous RAM with one write port and one registered read port, so an FPGA flow can map it to block RAM. A down-counter sets the length of a write. Two synchronous active-high resets are kept apart. Power-on reset clears all control state. Warm reset cancels a write in flight and records that it did so, but keeps the address and data registers intact so software can retry the write.

Top module: `nvm_wctl`

## Requirements
- R1: Register select codes are 0 = address, 1 = data, 2 = control, 3 = key. Control bits are bit0 read-start, bit1 write-start (busy), bit2 write-enable, bit3 write-error, bit4 write-done. Control bits 7:5 always read 0.
- R2: Software can set read-start and write-start but cannot clear them. Writing 0 to them has no effect, and only completion clears them.
- R3: Setting read-start loads the byte at the current address into the data register on the next clock. Read-start is 1 for exactly that one cycle.
- R4: The data register holds its value until a read finishes or software writes it.
- R5: A write starts only when 55h to the key register, then AAh to the key register, then a control write with bit1 set are the last three bus writes. Any other bus write between them cancels the sequence.
- R6: Write-start can be set only when write-enable is already 1. Power-on reset leaves write-enable at 0.
- R7: Clearing write-enable during a write neither stops nor changes that write.
- R8: A write lasts LAT clocks. Then write-start clears, the byte is stored, and write-done sets and stays set until software writes 0 to it.
- R9: Warm reset during a write sets write-error, clears write-start, leaves the stored byte unchanged, and preserves the address and data registers.
- R10: The key register always reads 0.
- R11: Power-on reset clears every control bit, including write-error.
- R12: While a write is busy, read-start requests and writes to the address and data registers are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reset, active high |
| warm_rst | input | 1 | Synchronous warm reset, active high |
| bus_sel | input | 2 | Register select |
| bus_we | input | 1 | Register write strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |

## Verification
The assertions assume that each bus write is a single-cycle strobe and that both resets are synchronous pulses sampled at a clock edge. They also assume that software accesses the registers only through the select codes of R1. The stimulus drives every input at the falling edge and holds each write strobe for exactly one cycle. It raises warm reset only for a single cycle, either during a busy write or while idle. Key sequences are broken on purpose with writes to other registers, and never by glitching the strobe.

// File: rtl/nvm_wctl_pkg.sv
package nvm_wctl_pkg;
  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_KEY  = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    KS_IDLE  = 2'd0,
    KS_FIRST = 2'd1,
    KS_ARMED = 2'd2
  } key_st_e;

  localparam int CB_RD   = 0;
  localparam int CB_WR   = 1;
  localparam int CB_WEN  = 2;
  localparam int CB_ERR  = 3;
  localparam int CB_DONE = 4;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;
endpackage

// File: rtl/nvm_key_seq.sv
module nvm_key_seq
  import nvm_wctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] sel,
  input  logic [7:0] wdata,
  output logic       armed
);
  key_st_e st_q;
  logic    key_hit;

  assign key_hit = wr_en && (sel == SEL_KEY);
  assign armed   = (st_q == KS_ARMED);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= KS_IDLE;
    end else if (wr_en) begin
      if (key_hit && wdata == KEY_FIRST)
        st_q <= KS_FIRST;
      else if (key_hit && wdata == KEY_SECOND && st_q == KS_FIRST)
        st_q <= KS_ARMED;
      else
        st_q <= KS_IDLE;
    end
  end

  // R5
  armed_after_second_key_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(key_hit && wdata == KEY_SECOND));

  // R5
  no_skip_first_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(armed) |-> $past(st_q == KS_FIRST));
endmodule

// File: rtl/nvm_wtimer.sv
module nvm_wtimer #(
  parameter int LAT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic fin
);
  localparam int CW = (LAT > 2) ? $clog2(LAT) : 1;
  localparam logic [CW-1:0] LOAD = CW'(LAT - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign busy = busy_q;
  assign fin  = busy_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= LOAD;
    end else if (fin) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LOAD);

  // R8
  fin_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    fin |=> !busy_q);
endmodule

// File: rtl/nvm_array.sv
module nvm_array #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    q <= mem[raddr];
  end
endmodule

// File: rtl/nvm_wctl.sv
module nvm_wctl
  import nvm_wctl_pkg::*;
#(
  parameter int AW  = 6,
  parameter int LAT = 16
) (
  input  logic       clk,
  input  logic       por,
  input  logic       warm_rst,
  input  logic [1:0] bus_sel,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata
);
  localparam int DW = 8;

  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          rd_q, wren_q, err_q, done_q;
  logic          busy, fin, armed, start, rd_go, arr_we, any_rst;
  logic          w_addr, w_data, w_ctrl;
  logic [DW-1:0] arr_q;

  assign any_rst = por || warm_rst;
  assign w_addr  = bus_we && (bus_sel == SEL_ADDR);
  assign w_data  = bus_we && (bus_sel == SEL_DATA);
  assign w_ctrl  = bus_we && (bus_sel == SEL_CTRL);
  assign start   = w_ctrl && bus_wdata[CB_WR] && armed && wren_q && !busy;
  assign rd_go   = w_ctrl && bus_wdata[CB_RD] && !busy && !start;
  assign arr_we  = fin && !any_rst;

  nvm_key_seq u_key (
    .clk   (clk),
    .rst   (any_rst),
    .wr_en (bus_we),
    .sel   (bus_sel),
    .wdata (bus_wdata),
    .armed (armed)
  );

  nvm_wtimer #(.LAT(LAT)) u_tmr (
    .clk   (clk),
    .rst   (any_rst),
    .start (start),
    .busy  (busy),
    .fin   (fin)
  );

  nvm_array #(.AW(AW), .DW(DW)) u_arr (
    .clk   (clk),
    .we    (arr_we),
    .waddr (addr_q),
    .wdata (data_q),
    .raddr (addr_q),
    .q     (arr_q)
  );

  always_ff @(posedge clk) begin
    if (por) begin
      addr_q <= '0;
      data_q <= '0;
      rd_q   <= 1'b0;
      wren_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (warm_rst) begin
      rd_q <= 1'b0;
      if (busy) err_q <= 1'b1;
    end else begin
      rd_q <= rd_go;
      if (rd_q)
        data_q <= arr_q;
      else if (w_data && !busy)
        data_q <= bus_wdata;
      if (w_addr && !busy)
        addr_q <= bus_wdata[AW-1:0];
      if (w_ctrl) begin
        wren_q <= bus_wdata[CB_WEN];
        err_q  <= bus_wdata[CB_ERR];
        done_q <= bus_wdata[CB_DONE];
      end
      if (fin) done_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (sel_e'(bus_sel))
      SEL_ADDR: bus_rdata = DW'(addr_q);
      SEL_DATA: bus_rdata = data_q;
      SEL_CTRL: begin
        bus_rdata[CB_RD]   = rd_q;
        bus_rdata[CB_WR]   = busy;
        bus_rdata[CB_WEN]  = wren_q;
        bus_rdata[CB_ERR]  = err_q;
        bus_rdata[CB_DONE] = done_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  // R6
  wr_needs_wren_chk: assert property (@(posedge clk) disable iff (any_rst)
    $rose(busy) |-> $past(wren_q));

  // R8
  end_sets_done_chk: assert property (@(posedge clk) disable iff (por)
    $fell(busy) |-> (done_q || $past(warm_rst) || $past(por)));

  // R3
  rd_one_cycle_chk: assert property (@(posedge clk) disable iff (any_rst)
    rd_q |=> (!rd_q && data_q == $past(arr_q)));

  // R12
  addr_frozen_busy_chk: assert property (@(posedge clk) disable iff (por)
    (busy && w_addr) |=> $stable(addr_q));

  // R9
  warm_abort_err_chk: assert property (@(posedge clk) disable iff (por)
    (warm_rst && busy) |=> (err_q && !busy));
endmodule

// File: tb/nvm_wctl_test.sv
module nvm_wctl_test;
  localparam int AW  = 6;
  localparam int LAT = 16;

  logic       clk = 1'b0;
  logic       por = 1'b1;
  logic       warm_rst = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  nvm_wctl #(.AW(AW), .LAT(LAT)) uut (
    .clk       (clk),
    .por       (por),
    .warm_rst  (warm_rst),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata)
  );

  localparam logic [15:0] VEC [8] = '{
    16'h00_3C, 16'h01_C3, 16'h3F_FF, 16'h05_00,
    16'h12_A5, 16'h20_5A, 16'h2A_81, 16'h05_7E
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wbus(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rbus(input logic [1:0] s, output logic [7:0] v);
    bus_sel = s;
    #1 v = bus_rdata;
  endtask

  task automatic start_write(input logic [7:0] a, input logic [7:0] d);
    wbus(2'd0, a);
    wbus(2'd1, d);
    wbus(2'd2, 8'h04);
    wbus(2'd3, 8'h55);
    wbus(2'd3, 8'hAA);
    wbus(2'd2, 8'h06);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] v);
    wbus(2'd0, a);
    wbus(2'd2, 8'h01);
    @(negedge clk);
    rbus(2'd1, v);
  endtask

  initial begin
    #(4 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: got hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    por = 1'b0;
    @(negedge clk);

    rbus(2'd2, v); chk("R11 ctrl after power-on", v, 8'h00);
    rbus(2'd3, v); chk("R10 key reads zero", v, 8'h00);
    rbus(2'd1, v); chk("R11 data after power-on", v, 8'h00);

    for (int i = 0; i < 8; i++) begin
      start_write(VEC[i][15:8], VEC[i][7:0]);
      rbus(2'd2, v); chk("R8 busy after start", v, 8'h06);
      repeat (LAT - 1) @(negedge clk);
      rbus(2'd2, v); chk("R8 still busy at LAT-1", v, 8'h06);
      @(negedge clk);
      rbus(2'd2, v); chk("R8 done after LAT", v, 8'h14);
      repeat (3) @(negedge clk);
      rbus(2'd2, v); chk("R8 done sticky", v, 8'h14);
      wbus(2'd2, 8'h04);
      rbus(2'd2, v); chk("R8 done cleared by software", v, 8'h04);
      wbus(2'd0, VEC[i][15:8]);
      wbus(2'd2, 8'h01);
      rbus(2'd2, v); chk("R3 read-start set one cycle", v, 8'h01);
      @(negedge clk);
      rbus(2'd2, v); chk("R3 read-start self-clears", v, 8'h00);
      rbus(2'd1, v); chk("R3 readback", v, VEC[i][7:0]);
    end

    // R1 upper bits
    wbus(2'd2, 8'hE4);
    rbus(2'd2, v); chk("R1 upper control bits zero", v, 8'h04);

    // R6 write-enable off
    wbus(2'd0, 8'h12); wbus(2'd1, 8'h11); wbus(2'd2, 8'h00);
    wbus(2'd3, 8'h55); wbus(2'd3, 8'hAA); wbus(2'd2, 8'h02);
    rbus(2'd2, v); chk("R6 no start without enable", v, 8'h00);
    repeat (LAT + 2) @(negedge clk);
    do_read(8'h12, v); chk("R6 store unchanged", v, 8'hA5);

    // R5 broken by an address write
    wbus(2'd0, 8'h20); wbus(2'd1, 8'h22); wbus(2'd2, 8'h04);
    wbus(2'd3, 8'h55); wbus(2'd0, 8'h20); wbus(2'd3, 8'hAA); wbus(2'd2, 8'h06);
    rbus(2'd2, v); chk("R5 interrupted sequence", v, 8'h04);
    // R5 wrong order
    wbus(2'd3, 8'hAA); wbus(2'd3, 8'h55); wbus(2'd2, 8'h06);
    rbus(2'd2, v); chk("R5 reversed keys", v, 8'h04);
    // R5 broken by a data write after both keys
    wbus(2'd3, 8'h55); wbus(2'd3, 8'hAA); wbus(2'd1, 8'h22); wbus(2'd2, 8'h06);
    rbus(2'd2, v); chk("R5 write between key and start", v, 8'h04);
    repeat (LAT + 2) @(negedge clk);
    do_read(8'h20, v); chk("R5 store unchanged", v, 8'h5A);

    // R4 data register holds
    wbus(2'd1, 8'h6B);
    repeat (5) @(negedge clk);
    rbus(2'd1, v); chk("R4 software data holds", v, 8'h6B);

    // R12, R2, R7 during a busy write
    start_write(8'h2A, 8'h3D);
    wbus(2'd0, 8'h01);
    rbus(2'd0, v); chk("R12 address write ignored while busy", v, 8'h2A);
    wbus(2'd1, 8'h99);
    rbus(2'd1, v); chk("R12 data write ignored while busy", v, 8'h3D);
    wbus(2'd2, 8'h05);
    rbus(2'd2, v); chk("R12 read-start ignored while busy", v, 8'h06);
    wbus(2'd2, 8'h00);
    rbus(2'd2, v); chk("R2 R7 start bit not clearable", v, 8'h02);
    repeat (LAT + 2) @(negedge clk);
    rbus(2'd2, v); chk("R7 write completes", v, 8'h10);
    do_read(8'h2A, v); chk("R7 new byte stored", v, 8'h3D);

    // R9 warm reset during a write
    start_write(8'h05, 8'h99);
    repeat (4) @(negedge clk);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    rbus(2'd2, v); chk("R9 error set, start cleared", v, 8'h0C);
    rbus(2'd0, v); chk("R9 address kept", v, 8'h05);
    rbus(2'd1, v); chk("R9 data kept", v, 8'h99);
    repeat (LAT + 2) @(negedge clk);
    rbus(2'd2, v); chk("R9 no late completion", v, 8'h0C);
    wbus(2'd2, 8'h08);
    @(negedge clk);
    por = 1'b1;
    @(negedge clk);
    por = 1'b0;
    rbus(2'd2, v); chk("R11 power-on clears error", v, 8'h00);
    do_read(8'h05, v); chk("R9 store not written", v, 8'h7E);

    // R11 warm reset while idle keeps error
    wbus(2'd2, 8'h08);
    warm_rst = 1'b1;
    @(negedge clk);
    warm_rst = 1'b0;
    rbus(2'd2, v); chk("R11 warm reset keeps error", v, 8'h08);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule